// File: doc/BRIEF.md
# Critical-Word-First Cache Line Refill Controller

This block refills one cache line after a miss. It talks to a memory port that returns one word per beat. It accepts a miss that carries the line address and the word offset the CPU asked for. It then sends one burst request to memory. In critical-first mode the burst starts at the missed word and wraps around the end of the line. In early-restart mode the burst starts at word zero and runs in address order.

Whichever order is used, the requested word goes to the CPU on a dedicated release port as soon as its beat lands. The CPU does not wait for the rest of the line. Every beat is also written into an internal line buffer and passed on, registered, to the cache data array. A CPU read port can fetch any word of the line being filled. A word that has already arrived is served from the buffer. A word still in flight holds the read off until its beat is written. When the last word is written, a one-cycle completion pulse is raised and the controller takes the next miss.

Top module: `cwf_line_fill`

## Requirements
- R1: After reset, `miss_ready` is 1, and `mem_req_valid`, `mem_rready`, `arr_we`, `crit_valid`, `line_done` and `cpu_rd_ack` are all 0.
- R2: When `crit_first` is 1 at miss acceptance, `mem_req_off` equals `miss_off`. The beats are written to offsets k, k+1, …, WORDS-1, 0, …, k-1, where k is the missed offset.
- R3: When `crit_first` is 0 at miss acceptance, `mem_req_off` is 0 and the beats are written to offsets 0 to WORDS-1 in ascending order.
- R4: In both modes, `crit_valid` is high for exactly one cycle per fill. That cycle is the one after the beat carrying the missed word, and `crit_data` then equals that beat's data.
- R5: Each accepted beat (`mem_rvalid` and `mem_rready` both 1) gives exactly one `arr_we` cycle on the next cycle, carrying the line address, the beat's offset and the beat's data. A fill writes exactly WORDS words.
- R6: A cycle with `mem_rvalid` low writes nothing and does not move the word position. The next valid beat is written to the offset that was due.
- R7: `line_done` is high for exactly one cycle per fill. That cycle is the one that carries the last word's `arr_we`, and `miss_ready` is 1 in the same cycle.
- R8: A CPU read (`cpu_rd_req` held with `cpu_rd_off`) of a word that has already been written to the line buffer is acknowledged with that word in `cpu_rd_data`. A read of a word not yet written gives no `cpu_rd_ack` until the word arrives. The buffer keeps serving reads of the last line after the fill ends.
- R9: While a fill is in progress (`miss_ready` is 0), `miss_valid` is ignored: the line being filled does not change and no second request follows.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and `mem_req_line` and `mem_req_off` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Controller idle, miss accepted this cycle if valid |
| miss_line | input | LINE_W | Line address of the miss |
| miss_off | input | OFF_W | Word offset requested by the CPU |
| crit_first | input | 1 | 1: wrapped burst from the missed word; 0: in-order burst |
| mem_req_valid | output | 1 | Burst request to memory |
| mem_req_ready | input | 1 | Memory accepts the burst request |
| mem_req_line | output | LINE_W | Line address of the burst |
| mem_req_off | output | OFF_W | First word offset of the burst |
| mem_rvalid | input | 1 | Data beat valid |
| mem_rready | output | 1 | Controller accepts data beats |
| mem_rdata | input | WORD_W | Data beat |
| crit_valid | output | 1 | Requested word released to the CPU |
| crit_data | output | WORD_W | Requested word |
| arr_we | output | 1 | Data array write strobe |
| arr_line | output | LINE_W | Data array line address |
| arr_off | output | OFF_W | Data array word offset |
| arr_data | output | WORD_W | Data array write word |
| line_done | output | 1 | Last word written, line complete |
| cpu_rd_req | input | 1 | CPU read of a word of the current line |
| cpu_rd_off | input | OFF_W | Word offset of the CPU read |
| cpu_rd_ack | output | 1 | CPU read served |
| cpu_rd_data | output | WORD_W | CPU read data |

## Verification
The assertions check on every cycle the properties that depend only on local timing. They cover the offset step from one array write to the next, including the wrap, and the first write landing at the requested offset. They also cover the one-cycle link from accepted beat to write, the absence of writes on idle beat cycles, the write count at completion, the single release of the requested word with matching data, and the request holding steady under backpressure. Only the bench scenarios can show that the data written and released actually matches what memory sent for each offset. The same holds for a read of a word still in flight stalling until that word lands, for a miss raised mid-fill leaving the line untouched, and for both orderings working across many start offsets and irregular beat gaps.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_CRIT   = 1'b1
  } fill_order_e;

endpackage

// File: rtl/cwf_fill_fsm.sv
module cwf_fill_fsm
  import cwf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic miss_valid,
  input  logic req_ready,
  input  logic rvalid,
  input  logic last_beat,
  output logic miss_ready,
  output logic req_valid,
  output logic rready,
  output logic accept,
  output logic beat
);

  fill_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE: if (miss_valid)         state_d = FS_REQ;
      FS_REQ:  if (req_ready)          state_d = FS_FILL;
      FS_FILL: if (rvalid && last_beat) state_d = FS_IDLE;
      default:                         state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= FS_IDLE;
    else     state_q <= state_d;
  end

  assign miss_ready = (state_q == FS_IDLE);
  assign req_valid  = (state_q == FS_REQ);
  assign rready     = (state_q == FS_FILL);
  assign accept     = miss_ready && miss_valid;
  assign beat       = rready && rvalid;

endmodule

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq #(
  parameter int WORDS = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [OFF_W-1:0] start_off,
  input  logic             step,
  output logic [OFF_W-1:0] cur_off,
  output logic             last
);

  localparam logic [OFF_W-1:0] TOP_OFF = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] count_q;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_next;

  // wrap explicitly so a line size that is not a power of two still works
  assign off_next = (off_q == TOP_OFF) ? '0 : off_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      off_q   <= '0;
    end else if (load) begin
      count_q <= '0;
      off_q   <= start_off;
    end else if (step) begin
      count_q <= count_q + 1'b1;
      off_q   <= off_next;
    end
  end

  assign cur_off = off_q;
  assign last    = (count_q == TOP_OFF);

endmodule

// File: rtl/cwf_line_ram.sv
module cwf_line_ram #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              we,
  input  logic [OFF_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [OFF_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata,
  output logic [WORDS-1:0]  present
);

  logic [WORD_W-1:0] store [WORDS];

  // simple dual-port array, no reset, registered read
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_present
    always_ff @(posedge clk) begin
      if (rst || clr)
        present[w] <= 1'b0;
      else if (we && (waddr == OFF_W'(w)))
        present[w] <= 1'b1;
    end
  end

endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
  import cwf_pkg::*;
#(
  parameter int LINE_W = 20,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [LINE_W-1:0] miss_line,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic              crit_first,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [OFF_W-1:0]  mem_req_off,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              crit_valid,
  output logic [WORD_W-1:0] crit_data,
  output logic              arr_we,
  output logic [LINE_W-1:0] arr_line,
  output logic [OFF_W-1:0]  arr_off,
  output logic [WORD_W-1:0] arr_data,
  output logic              line_done,
  input  logic              cpu_rd_req,
  input  logic [OFF_W-1:0]  cpu_rd_off,
  output logic              cpu_rd_ack,
  output logic [WORD_W-1:0] cpu_rd_data
);

  logic              accept;
  logic              beat;
  logic              last_beat;
  logic [OFF_W-1:0]  cur_off;
  logic [OFF_W-1:0]  start_d;
  logic [LINE_W-1:0] line_q;
  logic [OFF_W-1:0]  crit_q;
  logic [OFF_W-1:0]  start_q;
  logic [WORDS-1:0]  present;
  fill_order_e       order;

  assign order   = crit_first ? ORDER_CRIT : ORDER_LINEAR;
  assign start_d = (order == ORDER_CRIT) ? miss_off : '0;

  cwf_fill_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .req_ready  (mem_req_ready),
    .rvalid     (mem_rvalid),
    .last_beat  (last_beat),
    .miss_ready (miss_ready),
    .req_valid  (mem_req_valid),
    .rready     (mem_rready),
    .accept     (accept),
    .beat       (beat)
  );

  cwf_beat_seq #(.WORDS(WORDS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .start_off (start_d),
    .step      (beat),
    .cur_off   (cur_off),
    .last      (last_beat)
  );

  cwf_line_ram #(.WORDS(WORDS), .WORD_W(WORD_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .we      (beat),
    .waddr   (cur_off),
    .wdata   (mem_rdata),
    .raddr   (cpu_rd_off),
    .rdata   (cpu_rd_data),
    .present (present)
  );

  // miss context, captured once per fill
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      crit_q  <= '0;
      start_q <= '0;
    end else if (accept) begin
      line_q  <= miss_line;
      crit_q  <= miss_off;
      start_q <= start_d;
    end
  end

  assign mem_req_line = line_q;
  assign mem_req_off  = start_q;

  // registered beat outputs toward the data array and the CPU
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we     <= 1'b0;
      arr_line   <= '0;
      arr_off    <= '0;
      arr_data   <= '0;
      crit_valid <= 1'b0;
      crit_data  <= '0;
      line_done  <= 1'b0;
      cpu_rd_ack <= 1'b0;
    end else begin
      arr_we     <= beat;
      line_done  <= beat && last_beat;
      crit_valid <= beat && (cur_off == crit_q);
      cpu_rd_ack <= cpu_rd_req && present[cpu_rd_off];
      if (beat) begin
        arr_line <= line_q;
        arr_off  <= cur_off;
        arr_data <= mem_rdata;
      end
      if (beat && (cur_off == crit_q))
        crit_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int LINE_W = 20,
  parameter int WORD_W = 32,
  parameter int WORDS  = 8,
  localparam int OFF_W = $clog2(WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [LINE_W-1:0] mem_req_line,
  input logic [OFF_W-1:0]  mem_req_off,
  input logic              mem_rvalid,
  input logic              mem_rready,
  input logic              arr_we,
  input logic [OFF_W-1:0]  arr_off,
  input logic [WORD_W-1:0] arr_data,
  input logic              crit_valid,
  input logic [WORD_W-1:0] crit_data,
  input logic              line_done,
  input logic              cpu_rd_req,
  input logic              cpu_rd_ack
);

  logic [OFF_W:0]   wr_cnt;
  logic             first_q;
  logic             crit_seen;
  logic [OFF_W-1:0] prev_off;
  logic [OFF_W-1:0] req_off_q;
  logic [OFF_W-1:0] next_off;

  assign next_off = (prev_off == OFF_W'(WORDS - 1)) ? '0 : prev_off + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt    <= '0;
      first_q   <= 1'b1;
      crit_seen <= 1'b0;
      prev_off  <= '0;
      req_off_q <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) req_off_q <= mem_req_off;
      if (arr_we) begin
        prev_off <= arr_off;
        first_q  <= 1'b0;
        wr_cnt   <= wr_cnt + 1'b1;
      end
      if (crit_valid) crit_seen <= 1'b1;
      if (line_done) begin
        wr_cnt    <= '0;
        first_q   <= 1'b1;
        crit_seen <= 1'b0;
      end
    end
  end

  // R2
  wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && !first_q) |-> (arr_off == next_off));

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_we && first_q) |-> (arr_off == req_off_q));

  // R5
  beat_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rvalid && mem_rready) |=> arr_we);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rvalid && mem_rready) |=> !arr_we);

  // R5
  line_count_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (arr_we && (wr_cnt == (OFF_W+1)'(WORDS - 1))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |=> !line_done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> miss_ready);

  // R4
  crit_once_chk: assert property (@(posedge clk) disable iff (rst)
    crit_valid |-> (arr_we && (arr_data == crit_data) && !crit_seen));

  // R4
  crit_released_chk: assert property (@(posedge clk) disable iff (rst)
    line_done |-> (crit_seen || crit_valid));

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_off) && $stable(mem_req_line)));

  // R9
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || mem_rready) |-> !miss_ready);

  // R8
  rd_ack_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rd_ack |-> $past(cpu_rd_req));

endmodule

bind cwf_line_fill cwf_line_fill_chk #(
  .LINE_W (LINE_W),
  .WORD_W (WORD_W),
  .WORDS  (WORDS)
) i_cwf_chk (.*);

// File: tb/test_cwf_line_fill.sv
module test_cwf_line_fill;

  localparam int LINE_W = 20;
  localparam int WORD_W = 32;
  localparam int WORDS  = 8;
  localparam int OFF_W  = $clog2(WORDS);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              miss_valid = 1'b0;
  logic              miss_ready;
  logic [LINE_W-1:0] miss_line = '0;
  logic [OFF_W-1:0]  miss_off = '0;
  logic              crit_first = 1'b0;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b0;
  logic [LINE_W-1:0] mem_req_line;
  logic [OFF_W-1:0]  mem_req_off;
  logic              mem_rvalid = 1'b0;
  logic              mem_rready;
  logic [WORD_W-1:0] mem_rdata = '0;
  logic              crit_valid;
  logic [WORD_W-1:0] crit_data;
  logic              arr_we;
  logic [LINE_W-1:0] arr_line;
  logic [OFF_W-1:0]  arr_off;
  logic [WORD_W-1:0] arr_data;
  logic              line_done;
  logic              cpu_rd_req = 1'b0;
  logic [OFF_W-1:0]  cpu_rd_off = '0;
  logic              cpu_rd_ack;
  logic [WORD_W-1:0] cpu_rd_data;

  cwf_line_fill #(.LINE_W(LINE_W), .WORD_W(WORD_W), .WORDS(WORDS)) i_cwf_line_fill (.*);

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // monitor state
  int                wr_n, crit_n, done_n;
  logic [OFF_W-1:0]  wr_off [WORDS];
  logic [WORD_W-1:0] wr_dat [WORDS];
  bit                wr_seen [WORDS];
  logic [WORD_W-1:0] crit_d;
  logic [LINE_W-1:0] cur_line;
  bit                line_bad;
  logic [OFF_W-1:0]  got_req_off;

  function automatic logic [WORD_W-1:0] word_of(logic [LINE_W-1:0] ln, logic [OFF_W-1:0] off);
    return (WORD_W'(ln) * 32'h9E3779B1) ^ (WORD_W'(off) * 32'h01000193) ^ 32'h5A5A0000;
  endfunction

  function automatic logic [OFF_W-1:0] exp_off(logic [OFF_W-1:0] start, int i);
    return OFF_W'((int'(start) + i) % WORDS);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      summary();
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (arr_we) begin
        if (wr_n < WORDS) begin
          wr_off[wr_n] = arr_off;
          wr_dat[wr_n] = arr_data;
        end
        wr_seen[arr_off] = 1'b1;
        if (arr_line != cur_line) line_bad = 1'b1;
        wr_n++;
      end
      if (crit_valid) begin
        crit_n++;
        crit_d = crit_data;
      end
      if (line_done) done_n++;
    end
  end

  task automatic mem_model(int gapmax, bit exp_crit, logic [OFF_W-1:0] k);
    logic [OFF_W-1:0] start;
    int d;
    while (!mem_req_valid) @(negedge clk);
    d = $urandom % 4;
    start = mem_req_off;
    for (int j = 0; j < d; j++) begin
      @(negedge clk);
      // R10: request held under backpressure
      check(mem_req_valid && mem_req_off == start && mem_req_line == cur_line,
            "R10", "request held", mem_req_off, start);
    end
    got_req_off = mem_req_off;
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    if (exp_crit) check(got_req_off == k, "R2", "burst start", got_req_off, k);
    else          check(got_req_off == '0, "R3", "burst start", got_req_off, 0);
    for (int i = 0; i < WORDS; i++) begin
      int g;
      g = $urandom % (gapmax + 1);
      for (int j = 0; j < g; j++) @(negedge clk);
      while (!mem_rready) @(negedge clk);
      mem_rvalid = 1'b1;
      mem_rdata  = word_of(cur_line, exp_off(got_req_off, i));
      @(negedge clk);
      mem_rvalid = 1'b0;
    end
  endtask

  task automatic cpu_read(logic [OFF_W-1:0] off, int delay);
    int waited;
    for (int j = 0; j < delay; j++) @(negedge clk);
    cpu_rd_req = 1'b1;
    cpu_rd_off = off;
    waited = 0;
    @(negedge clk);
    while (!cpu_rd_ack && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    cpu_rd_req = 1'b0;
    check(cpu_rd_ack, "R8", "read served", cpu_rd_ack, 1);
    // R8: never acknowledged before the word was written
    check(wr_seen[off], "R8", "read waited for word", wr_seen[off], 1);
    check(cpu_rd_data == word_of(cur_line, off), "R8", "read data",
          cpu_rd_data, word_of(cur_line, off));
  endtask

  task automatic run_fill(logic [LINE_W-1:0] ln, logic [OFF_W-1:0] k, bit cf,
                          int gapmax, bit do_rd, logic [OFF_W-1:0] rd_off,
                          int rd_delay, bit intrude);
    logic [OFF_W-1:0] start;
    while (!miss_ready) @(negedge clk);
    wr_n = 0; crit_n = 0; done_n = 0; line_bad = 1'b0; crit_d = '0;
    for (int w = 0; w < WORDS; w++) wr_seen[w] = 1'b0;
    cur_line   = ln;
    miss_valid = 1'b1;
    miss_line  = ln;
    miss_off   = k;
    crit_first = cf;
    @(negedge clk);
    miss_valid = 1'b0;
    fork
      mem_model(gapmax, cf, k);
      if (do_rd) cpu_read(rd_off, rd_delay);
      if (intrude) begin
        for (int j = 0; j < 3; j++) @(negedge clk);
        miss_valid = 1'b1;
        miss_line  = ln ^ 20'h5555;
        miss_off   = k + 1'b1;
        crit_first = ~cf;
        for (int j = 0; j < 2; j++) @(negedge clk);
        miss_valid = 1'b0;
      end
    join
    for (int j = 0; j < 3; j++) @(negedge clk);
    start = cf ? k : '0;
    check(wr_n == WORDS, "R5", "write count", wr_n, WORDS);
    for (int i = 0; i < WORDS; i++) begin
      check(wr_off[i] == exp_off(start, i), cf ? "R2" : "R3", "write order",
            wr_off[i], exp_off(start, i));
      check(wr_dat[i] == word_of(ln, wr_off[i]), "R5", "write data",
            wr_dat[i], word_of(ln, wr_off[i]));
    end
    check(crit_n == 1, "R4", "critical release count", crit_n, 1);
    check(crit_d == word_of(ln, k), "R4", "critical data", crit_d, word_of(ln, k));
    check(done_n == 1, "R7", "done pulse cycles", done_n, 1);
    check(!line_bad, "R9", "line address kept", line_bad, 0);
    check(!mem_req_valid && miss_ready, "R9", "no stray request after fill",
          mem_req_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int j = 0; j < 5; j++) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(miss_ready && !mem_req_valid && !mem_rready && !arr_we && !crit_valid
          && !line_done && !cpu_rd_ack, "R1", "reset state",
          {miss_ready, mem_req_valid, mem_rready, arr_we, crit_valid, line_done, cpu_rd_ack},
          7'b1000000);

    // directed corners
    run_fill(20'h00100, 3'd0, 1'b1, 0, 1'b0, 3'd0, 0, 1'b0);      // R2 no wrap
    run_fill(20'h00200, 3'd7, 1'b1, 2, 1'b1, 3'd7, 0, 1'b0);      // R2 last word first, R8 stall
    run_fill(20'h00300, 3'd5, 1'b0, 1, 1'b1, 3'd5, 0, 1'b0);      // R3 early restart
    run_fill(20'h00400, 3'd5, 1'b1, 3, 1'b1, 3'd4, 0, 1'b1);      // R8 latest word, R9 intrusion
    run_fill(20'h00500, 3'd2, 1'b1, 6, 1'b0, 3'd0, 0, 1'b0);      // R6 long gaps
    cpu_read(3'd6, 1);                                            // R8 served after completion
    cpu_read(3'd2, 0);                                            // R8

    for (int n = 0; n < 24; n++) begin
      logic [LINE_W-1:0] ln;
      logic [OFF_W-1:0]  k, ro;
      ln = LINE_W'($urandom);
      k  = OFF_W'($urandom);
      ro = OFF_W'($urandom);
      run_fill(ln, k, 1'($urandom), $urandom % 4, 1'($urandom), ro,
               $urandom % 6, (n % 5) == 0);
    end
    summary();
  end

endmodule